// File: doc/BRIEF.md
# Microsequenced CPU Control Unit

This block is the control unit of a small CPU. Every cycle it drives a 15-bit vector of datapath control lines and reports its current micro-state. The datapath's instruction register supplies a 4-bit opcode. A 3-bit micro-program counter holds the micro-state. A control table indexed by that state supplies the control lines and a 2-bit selector, and the selector picks the next state. The next state is the fetch state, the state that a 16-entry opcode dispatch table gives, or the current state plus one.

A build parameter can select a flat implementation in its place. The flat version reads both the control lines and a 3-bit next state from a single 128-entry table indexed by the opcode and the state. Both variants must produce the same cycle-by-cycle sequence. The table contents are fixed constants that are computed at elaboration.

The micro-program has eight states. States 0 and 1 fetch and decode. States 2–3 load, states 4–5 perform a memory operand ALU operation, state 6 stores, and state 7 handles stop and branch instructions.

Top module: `mseq_ctrl_unit`

## Requirements
- R1: While `rst_i` is high at a clock edge, the state register loads 0, the fetch state. After that edge `state_o` reads 0 and `ctrl_o` shows the fetch control word.
- R2: States 0, 2 and 4 carry selector value 2 (increment), so each is followed by state 1, 3 and 5 respectively.
- R3: State 1 carries selector value 1 (dispatch). The next state depends on the opcode: 1 goes to state 2, 2 goes to state 6, 3 and 4 go to state 4, and 0 and 5 to 15 go to state 7.
- R4: States 3, 5 and 6 carry selector value 0, so the next state is the fetch state 0.
- R5: State 7 carries the reserved selector value 3, which behaves like value 0, so the next state is 0.
- R6: The control word for each state is: state 0 0x0007, state 1 0x0010, state 2 0x0068, state 3 0x0180, state 4 0x0620, state 5 0x1800, state 6 0x2068, state 7 0x4000.
- R7: The opcode has no effect on the next state in any state other than 1.
- R8: `ctrl_o` is a combinational function of the current state. It shows the word for the new state in the same cycle that the state changes.
- R9: The flat variant (`FLAT_IMPL`=1) produces the same state and control sequence as the selector variant for every opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| opcode_i | input | 4 | Opcode from the instruction register |
| ctrl_o | output | 15 | Datapath control lines for the current state |
| state_o | output | 3 | Current micro-state |

## Verification
The bench builds two instances side by side, one with `FLAT_IMPL`=0 and one with `FLAT_IMPL`=1, and leaves every width at its default. It drives both with the same opcode stream. Comparing the two on every sample brings the equivalence of the dispatch-and-selector path with the 128-entry table within reach, for all 16 opcodes. The reserved selector value and the opcode changes outside the dispatch state are exercised in both builds.

// File: rtl/mseq_pkg.sv
`timescale 1ns/1ps
package mseq_pkg;
   localparam int OPC_W = 4;
   localparam int ST_W  = 3;
   localparam int CTL_W = 15;
   localparam int SEL_W = 2;
   localparam int ROW_W = CTL_W + SEL_W;

   typedef enum logic [SEL_W-1:0] {
      NX_FETCH    = 2'd0,
      NX_DISPATCH = 2'd1,
      NX_INCR     = 2'd2,
      NX_RSVD     = 2'd3
   } nsel_e;

   localparam logic [ST_W-1:0] ST_FETCH = 3'd0;

   // first micro-state of each opcode's routine
   function automatic logic [ST_W-1:0] dispatch_entry(input logic [OPC_W-1:0] opc);
      logic [ST_W-1:0] s;
      case (opc)
         4'd1:       s = 3'd2;
         4'd2:       s = 3'd6;
         4'd3, 4'd4: s = 3'd4;
         default:    s = 3'd7;
      endcase
      return s;
   endfunction

   // {selector, control word} per micro-state
   function automatic logic [ROW_W-1:0] ctrl_entry(input logic [ST_W-1:0] st);
      logic [ROW_W-1:0] r;
      case (st)
         3'd0:    r = {NX_INCR,     15'h0007};
         3'd1:    r = {NX_DISPATCH, 15'h0010};
         3'd2:    r = {NX_INCR,     15'h0068};
         3'd3:    r = {NX_FETCH,    15'h0180};
         3'd4:    r = {NX_INCR,     15'h0620};
         3'd5:    r = {NX_FETCH,    15'h1800};
         3'd6:    r = {NX_FETCH,    15'h2068};
         default: r = {NX_RSVD,     15'h4000};
      endcase
      return r;
   endfunction
endpackage

// File: rtl/mseq_dispatch_rom.sv
`timescale 1ns/1ps
module mseq_dispatch_rom #(
   parameter int OPC_W = mseq_pkg::OPC_W,
   parameter int ST_W  = mseq_pkg::ST_W
) (
   input  logic [OPC_W-1:0] opc_i,
   output logic [ST_W-1:0]  start_o
);
   localparam int DEPTH = 1 << OPC_W;
   logic [ST_W-1:0] tbl [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign tbl[i] = mseq_pkg::dispatch_entry(OPC_W'(i));
   end

   assign start_o = tbl[opc_i];
endmodule

// File: rtl/mseq_ctrl_rom.sv
`timescale 1ns/1ps
module mseq_ctrl_rom #(
   parameter int ST_W  = mseq_pkg::ST_W,
   parameter int CTL_W = mseq_pkg::CTL_W,
   parameter int SEL_W = mseq_pkg::SEL_W
) (
   input  logic [ST_W-1:0]  st_i,
   output logic [CTL_W-1:0] ctrl_o,
   output logic [SEL_W-1:0] sel_o
);
   localparam int DEPTH = 1 << ST_W;
   localparam int ROW_W = CTL_W + SEL_W;
   logic [ROW_W-1:0] tbl [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign tbl[i] = mseq_pkg::ctrl_entry(ST_W'(i));
   end

   assign {sel_o, ctrl_o} = tbl[st_i];
endmodule

// File: rtl/mseq_next_sel.sv
`timescale 1ns/1ps
module mseq_next_sel #(
   parameter int ST_W  = mseq_pkg::ST_W,
   parameter int SEL_W = mseq_pkg::SEL_W
) (
   input  logic [SEL_W-1:0] sel_i,
   input  logic [ST_W-1:0]  st_i,
   input  logic [ST_W-1:0]  disp_i,
   output logic [ST_W-1:0]  next_o
);
   import mseq_pkg::*;
   nsel_e sel;
   assign sel = nsel_e'(sel_i);

   always_comb begin
      case (sel)
         NX_DISPATCH: next_o = disp_i;
         NX_INCR:     next_o = st_i + ST_W'(1);
         default:     next_o = ST_FETCH;   // fetch and reserved
      endcase
   end
endmodule

// File: rtl/mseq_flat_rom.sv
`timescale 1ns/1ps
module mseq_flat_rom #(
   parameter int OPC_W = mseq_pkg::OPC_W,
   parameter int ST_W  = mseq_pkg::ST_W,
   parameter int CTL_W = mseq_pkg::CTL_W
) (
   input  logic [OPC_W-1:0] opc_i,
   input  logic [ST_W-1:0]  st_i,
   output logic [CTL_W-1:0] ctrl_o,
   output logic [ST_W-1:0]  next_o
);
   import mseq_pkg::*;
   localparam int IDX_W = OPC_W + ST_W;
   localparam int DEPTH = 1 << IDX_W;
   localparam int ROW_W = CTL_W + ST_W;

   function automatic logic [ROW_W-1:0] flat_row(input logic [IDX_W-1:0] idx);
      logic [OPC_W-1:0] o;
      logic [ST_W-1:0]  s, n;
      logic [mseq_pkg::ROW_W-1:0] c;
      {o, s} = idx;
      c = ctrl_entry(s);
      case (nsel_e'(c[mseq_pkg::ROW_W-1 -: SEL_W]))
         NX_DISPATCH: n = dispatch_entry(o);
         NX_INCR:     n = s + ST_W'(1);
         default:     n = ST_FETCH;
      endcase
      return {c[CTL_W-1:0], n};
   endfunction

   logic [ROW_W-1:0] tbl [DEPTH];
   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign tbl[i] = flat_row(IDX_W'(i));
   end

   assign {ctrl_o, next_o} = tbl[{opc_i, st_i}];
endmodule

// File: rtl/mseq_ctrl_unit.sv
`timescale 1ns/1ps
module mseq_ctrl_unit #(
   parameter int OPC_W     = mseq_pkg::OPC_W,
   parameter int ST_W      = mseq_pkg::ST_W,
   parameter int CTL_W     = mseq_pkg::CTL_W,
   parameter int SEL_W     = mseq_pkg::SEL_W,
   parameter bit FLAT_IMPL = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [OPC_W-1:0] opcode_i,
   output logic [CTL_W-1:0] ctrl_o,
   output logic [ST_W-1:0]  state_o
);
   if (OPC_W != mseq_pkg::OPC_W) begin : g_bad_opc
      $error("OPC_W must match the microcode opcode width");
   end
   if (ST_W != mseq_pkg::ST_W) begin : g_bad_st
      $error("ST_W must match the microcode state width");
   end
   if (CTL_W != mseq_pkg::CTL_W || SEL_W != mseq_pkg::SEL_W) begin : g_bad_ctl
      $error("CTL_W/SEL_W must match the microcode word layout");
   end

   logic [ST_W-1:0] upc_q, upc_d;

   if (FLAT_IMPL) begin : g_flat
      mseq_flat_rom #(.OPC_W(OPC_W), .ST_W(ST_W), .CTL_W(CTL_W)) u_flat (
         .opc_i (opcode_i),
         .st_i  (upc_q),
         .ctrl_o(ctrl_o),
         .next_o(upc_d)
      );
   end else begin : g_seq
      logic [ST_W-1:0]  disp;
      logic [SEL_W-1:0] sel;

      mseq_dispatch_rom #(.OPC_W(OPC_W), .ST_W(ST_W)) u_disp (
         .opc_i  (opcode_i),
         .start_o(disp)
      );
      mseq_ctrl_rom #(.ST_W(ST_W), .CTL_W(CTL_W), .SEL_W(SEL_W)) u_ctl (
         .st_i  (upc_q),
         .ctrl_o(ctrl_o),
         .sel_o (sel)
      );
      mseq_next_sel #(.ST_W(ST_W), .SEL_W(SEL_W)) u_nxt (
         .sel_i (sel),
         .st_i  (upc_q),
         .disp_i(disp),
         .next_o(upc_d)
      );
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) upc_q <= mseq_pkg::ST_FETCH;
      else       upc_q <= upc_d;
   end

   assign state_o = upc_q;
endmodule

// File: rtl/mseq_ctrl_unit_chk.sv
`timescale 1ns/1ps
module mseq_ctrl_unit_chk (
   input logic        clk_i,
   input logic        rst_i,
   input logic [3:0]  opcode_i,
   input logic [14:0] ctrl_o,
   input logic [2:0]  state_o
);
   // R1
   reset_fetch_chk: assert property (@(posedge clk_i)
      $past(rst_i) |-> (state_o == 3'd0));

   // R2
   incr_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 3'd0 || state_o == 3'd2 || state_o == 3'd4) |=> (state_o == $past(state_o) + 3'd1));

   // R3
   dispatch_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 3'd1 && opcode_i == 4'd1) |=> (state_o == 3'd2));

   // R3
   dispatch_stop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 3'd1 && (opcode_i == 4'd0 || opcode_i >= 4'd5)) |=> (state_o == 3'd7));

   // R4
   return_fetch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 3'd3 || state_o == 3'd5 || state_o == 3'd6) |=> (state_o == 3'd0));

   // R5
   reserved_sel_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 3'd7) |=> (state_o == 3'd0));

   // R6
   fetch_word_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == 3'd0) |-> (ctrl_o == 15'h0007));

   // R8
   ctrl_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $stable(state_o) |-> $stable(ctrl_o));
endmodule

bind mseq_ctrl_unit mseq_ctrl_unit_chk u_chk (.*);

// File: tb/mseq_ctrl_unit_bench.sv
`timescale 1ns/1ps
module mseq_ctrl_unit_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  opc = 4'd0;
   logic [14:0] ctrl_a, ctrl_b;
   logic [2:0]  st_a, st_b;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   mseq_ctrl_unit #(.FLAT_IMPL(1'b0)) u_mseq_ctrl_unit (
      .clk_i(clk), .rst_i(rst), .opcode_i(opc), .ctrl_o(ctrl_a), .state_o(st_a));
   mseq_ctrl_unit #(.FLAT_IMPL(1'b1)) u_mseq_ctrl_unit_flat (
      .clk_i(clk), .rst_i(rst), .opcode_i(opc), .ctrl_o(ctrl_b), .state_o(st_b));

   typedef struct packed {
      logic [3:0]  op;
      logic [2:0]  len;
      logic [11:0] seq;   // {s3,s2,s1,s0}
   } vec_t;

   localparam vec_t VECS [16] = '{
      '{4'd0,  3'd3, {3'd0, 3'd7, 3'd1, 3'd0}},
      '{4'd1,  3'd4, {3'd3, 3'd2, 3'd1, 3'd0}},
      '{4'd2,  3'd3, {3'd0, 3'd6, 3'd1, 3'd0}},
      '{4'd3,  3'd4, {3'd5, 3'd4, 3'd1, 3'd0}},
      '{4'd4,  3'd4, {3'd5, 3'd4, 3'd1, 3'd0}},
      '{4'd5,  3'd3, {3'd0, 3'd7, 3'd1, 3'd0}},
      '{4'd6,  3'd3, {3'd0, 3'd7, 3'd1, 3'd0}},
      '{4'd7,  3'd3, {3'd0, 3'd7, 3'd1, 3'd0}},
      '{4'd8,  3'd3, {3'd0, 3'd7, 3'd1, 3'd0}},
      '{4'd9,  3'd3, {3'd0, 3'd7, 3'd1, 3'd0}},
      '{4'd10, 3'd3, {3'd0, 3'd7, 3'd1, 3'd0}},
      '{4'd11, 3'd3, {3'd0, 3'd7, 3'd1, 3'd0}},
      '{4'd12, 3'd3, {3'd0, 3'd7, 3'd1, 3'd0}},
      '{4'd13, 3'd3, {3'd0, 3'd7, 3'd1, 3'd0}},
      '{4'd14, 3'd3, {3'd0, 3'd7, 3'd1, 3'd0}},
      '{4'd15, 3'd3, {3'd0, 3'd7, 3'd1, 3'd0}}
   };

   // R6 control words
   function automatic logic [14:0] word_of(input logic [2:0] s);
      case (s)
         3'd0: return 15'h0007;
         3'd1: return 15'h0010;
         3'd2: return 15'h0068;
         3'd3: return 15'h0180;
         3'd4: return 15'h0620;
         3'd5: return 15'h1800;
         3'd6: return 15'h2068;
         default: return 15'h4000;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // state, word and flat-variant agreement at the current sample point
   task automatic check_state(input string req, input logic [2:0] exp_st);
      check(req, {29'd0, st_a}, {29'd0, exp_st});
      check("R6/R8 ctrl word", {17'd0, ctrl_a}, {17'd0, word_of(exp_st)});
      check("R9 flat state", {29'd0, st_b}, {29'd0, st_a});
      check("R9 flat ctrl", {17'd0, ctrl_b}, {17'd0, ctrl_a});
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      step();
      step();
      check_state("R1 reset state", 3'd0);
      rst = 1'b0;
      // table walk: R2 R3 R4 R5
      for (int v = 0; v < 16; v++) begin
         opc = VECS[v].op;
         for (int k = 0; k < int'(VECS[v].len); k++) begin
            check_state("R2/R3/R4 sequence", VECS[v].seq[3*k +: 3]);
            step();
         end
         check_state("R4/R5 return to fetch", 3'd0);
      end
      // R7: opcode change after dispatch does not alter the routine
      opc = 4'd1;
      step(); step();
      check_state("R3 load entry", 3'd2);
      opc = 4'd2;
      step();
      check_state("R7 opcode ignored in state 2", 3'd3);
      opc = 4'd0;
      step();
      check_state("R7 opcode ignored in state 3", 3'd0);
      // R7: opcode change during fetch state is also ignored until dispatch
      opc = 4'd7;
      step();
      opc = 4'd3;
      step();
      check_state("R7 dispatch uses opcode at state 1", 3'd4);
      // R1: reset in the middle of a routine
      rst = 1'b1;
      step();
      check_state("R1 mid-routine reset", 3'd0);
      step();
      check_state("R1 reset held", 3'd0);
      rst = 1'b0;
      step();
      check_state("R2 first step after reset", 3'd1);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule